// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block produces the two timing strobes a serial transmitter and receiver share: a sample enable and a bit-period enable, both one clock cycle wide. It works from the block clock. An optional fixed divide-by-8 prescale stage comes first. A programmable clock divisor then turns the prescaled enables into sample ticks. A bit divider counts sample ticks and emits one bit-period tick every `bdiv + 1` sample ticks. The resulting bit rate is f_clk / (P × cd × (bdiv + 1)), where P is 8 when the prescale is selected and 1 otherwise.

Configuration arrives as plain register values: the prescale select, the 16-bit divisor `cd` and the 8-bit divider `bdiv`, together with an enable. Choosing the best divisor pair for a target rate is left to software. The block is controlled by a two-state machine:
- **ST_IDLE**: the counters are held clear and no ticks are produced.
- **ST_RUN**: the counters advance.

The transitions are:
- **start**: ST_IDLE to ST_RUN, when `en` is high and `cd` is non-zero.
- **stop**: ST_RUN to ST_IDLE, when `en` falls or `cd` becomes zero.

While in ST_RUN, any change to the configuration inputs clears every counter, so the new rate takes effect from the next clock edge.

Top module: `baud_tick_gen`

## Requirements
- R1: With `div8_sel`=0 and divisor C≥1, the first `sample_tick` comes C−1 cycles after the first cycle in ST_RUN. Sample ticks then repeat every C cycles.
- R2: With `div8_sel`=1, the first `sample_tick` comes 8·C−1 cycles after the first cycle in ST_RUN. Sample ticks then repeat every 8·C cycles, so two sample ticks are never adjacent.
- R3: With `cd`=1, every prescaled enable is a sample tick: every cycle without the prescale, or every 8th cycle with it.
- R4: With `cd`=0, neither tick is ever produced.
- R5: `bit_tick` is a single-cycle pulse and only occurs together with `sample_tick`. It marks every (B+1)-th sample tick, starting with the (B+1)-th one after counting starts.
- R6: A `bdiv` value below 4 behaves exactly like 4.
- R7: A change of `div8_sel`, `cd` or `bdiv` while running suppresses ticks in the cycle of the change. All counters restart from zero at the next edge.
- R8: While `en` is low, no tick is produced and the counters are cleared, so re-enabling starts a fresh count.
- R9: During and right after reset, both outputs are low and the block is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable |
| div8_sel | input | 1 | Selects the divide-by-8 prescale stage |
| cd | input | 16 | Sample clock divisor; 0 stops the generator |
| bdiv | input | 8 | Bit divider; sample ticks per bit minus one, values below 4 act as 4 |
| sample_tick | output | 1 | One-cycle sample enable |
| bit_tick | output | 1 | One-cycle bit-period enable |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a count. If the design missed the change, the old counter value could already lie beyond the new terminal count. Such a design would then wrap the whole 16-bit range before ticking again. The stimulus runs a large divisor for part of a period, then shrinks it at a clock-cycle midpoint. It then checks two things: that the change cycle is silent, and that the first tick lands exactly the new period after the following edge. The other deep case is the upper end of the divisor range, where the first tick is reached only after 65534 cycles. It is covered by one long directed run.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bdg_state_t;

    localparam int unsigned BDG_CD_W    = 16;
    localparam int unsigned BDG_BD_W    = 8;
    localparam int unsigned BDG_PRE_DIV = 8;
    localparam int unsigned BDG_BD_MIN  = 4;
endpackage

// File: rtl/bdg_prescale.sv
module bdg_prescale #(
    parameter int unsigned RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic sel,
    output logic tick
);
    localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    generate
        if (RATIO > 1) begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt <= '0;
                else if (!live)
                    cnt <= '0;
                else if (sel)
                    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
            assign tick = live && (!sel || (cnt == LAST));
        end else begin : g_pass
            assign tick = live;
        end
    endgenerate
endmodule

// File: rtl/bdg_cd_count.sv
module bdg_cd_count #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         live,
    input  logic         step,
    input  logic [W-1:0] cd,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         at_end;

    assign at_end = ({1'b0, cnt} + {{W{1'b0}}, 1'b1}) == {1'b0, cd};
    assign tick   = live && step && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!live)
            cnt <= '0;
        else if (step)
            cnt <= at_end ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/bdg_bit_count.sv
module bdg_bit_count #(
    parameter int unsigned W   = 8,
    parameter int unsigned MIN = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         live,
    input  logic         step,
    input  logic [W-1:0] bdiv,
    output logic         tick
);
    localparam logic [W-1:0] FLOOR = W'(MIN);

    logic [W-1:0] limit;
    logic [W-1:0] cnt;
    logic         at_end;

    assign limit  = (bdiv < FLOOR) ? FLOOR : bdiv;
    assign at_end = (cnt == limit);
    assign tick   = live && step && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!live)
            cnt <= '0;
        else if (step)
            cnt <= at_end ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import bdg_pkg::*;
#(
    parameter int unsigned CD_W    = BDG_CD_W,
    parameter int unsigned BD_W    = BDG_BD_W,
    parameter int unsigned PRE_DIV = BDG_PRE_DIV,
    parameter int unsigned BD_MIN  = BDG_BD_MIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            div8_sel,
    input  logic [CD_W-1:0] cd,
    input  logic [BD_W-1:0] bdiv,
    output logic            sample_tick,
    output logic            bit_tick
);
    localparam int unsigned CFG_W = 1 + CD_W + BD_W;

    bdg_state_t      state, state_nx;
    logic [CFG_W-1:0] cfg_now, cfg_seen;
    logic            cfg_chg;
    logic            cd_ok;
    logic            live;
    logic            pre_tick, smp, bit_t;

    assign cfg_now = {div8_sel, cd, bdiv};
    assign cfg_chg = (cfg_now != cfg_seen);
    assign cd_ok   = (cd != '0);

    // configuration snapshot used to detect register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_seen <= '0;
        else
            cfg_seen <= cfg_now;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (en && cd_ok)    state_nx = ST_RUN;
            ST_RUN:  if (!en || !cd_ok)  state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        live = 1'b0;
        unique case (state)
            ST_IDLE: live = 1'b0;
            ST_RUN:  live = en && cd_ok && !cfg_chg;
            default: live = 1'b0;
        endcase
    end

    bdg_prescale #(.RATIO(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .sel   (div8_sel),
        .tick  (pre_tick)
    );

    bdg_cd_count #(.W(CD_W)) u_cd (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .step  (pre_tick),
        .cd    (cd),
        .tick  (smp)
    );

    bdg_bit_count #(.W(BD_W), .MIN(BD_MIN)) u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .step  (smp),
        .bdiv  (bdiv),
        .tick  (bit_t)
    );

    assign sample_tick = smp;
    assign bit_tick    = bit_t;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int unsigned CD_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            div8_sel,
    input logic [CD_W-1:0] cd,
    input logic            sample_tick,
    input logic            bit_tick
);
    AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick); // R5
    AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick); // R5
    AST_CD_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cd == '0) |-> (!sample_tick && !bit_tick)); // R4
    AST_DIV8_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (div8_sel && sample_tick) |=> !sample_tick); // R2
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !sample_tick); // R8
    AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cd) || !$stable(div8_sel)) |-> !sample_tick); // R7
    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!sample_tick && !bit_tick); // R9
        end
    end
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CD_W(CD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .div8_sel    (div8_sel),
    .cd          (cd),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // {div8_sel, cd, bdiv, first sample index, first bit index}
    localparam int VEC [NV][5] = '{
        '{0, 1,   4,  0,    4},
        '{0, 3,   4,  2,   14},
        '{1, 1,   4,  7,   39},
        '{1, 2,   5, 15,   95},
        '{0, 5,   0,  4,   24},
        '{0, 2,   2,  1,    9},
        '{0, 7, 255,  6, 1791},
        '{0, 1, 255,  0,  255}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        div8_sel = 1'b0;
    logic [15:0] cd = 16'd0;
    logic [7:0]  bdiv = 8'd0;
    logic        sample_tick, bit_tick;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en), .div8_sel(div8_sel),
        .cd(cd), .bdiv(bdiv), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // enable at a negedge; the next negedge observes run index 0
    task automatic measure(input int lim, output int s1, output int s2,
                           output int b1, output int orphan);
        s1 = -1; s2 = -1; b1 = -1; orphan = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (bit_tick && !sample_tick) orphan++;
            if (sample_tick) begin
                if (s1 < 0) s1 = i;
                else if (s2 < 0) s2 = i;
            end
            if (bit_tick && b1 < 0) b1 = i;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s1, s2, b1, orph, per;
        // R9: reset state
        #(CLK_PERIOD * 2 + 2);
        chk("R9 sample in reset", int'(sample_tick), 0);
        chk("R9 bit in reset", int'(bit_tick), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R9 sample after reset", int'(sample_tick), 0);

        // table walk: R1 R2 R3 R5 R6
        for (int v = 0; v < NV; v++) begin
            en = 1'b0;
            div8_sel = VEC[v][0][0];
            cd = 16'(VEC[v][1]);
            bdiv = 8'(VEC[v][2]);
            @(negedge clk); @(negedge clk);
            en = 1'b1;
            per = (VEC[v][0] != 0 ? 8 : 1) * VEC[v][1];
            measure(VEC[v][4] + per + 4, s1, s2, b1, orph);
            chk($sformatf("R1/R2/R3 first sample v%0d", v), s1, VEC[v][3]);
            chk($sformatf("R1/R2 sample period v%0d", v), s2 - s1, per);
            chk($sformatf("R5/R6 first bit v%0d", v), b1, VEC[v][4]);
            chk($sformatf("R5 bit without sample v%0d", v), orph, 0);
        end

        // R4: zero divisor
        en = 1'b0; div8_sel = 1'b0; cd = 16'd0; bdiv = 8'd4;
        @(negedge clk); en = 1'b1;
        measure(100, s1, s2, b1, orph);
        chk("R4 sample with cd=0", s1, -1);
        chk("R4 bit with cd=0", b1, -1);

        // R8: disabled, then fresh count after re-enable
        en = 1'b0; cd = 16'd4;
        measure(50, s1, s2, b1, orph);
        chk("R8 sample while disabled", s1, -1);
        en = 1'b1;
        measure(3, s1, s2, b1, orph);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        measure(6, s1, s2, b1, orph);
        chk("R8 restart from zero", s1, 3);

        // R7: divisor shrinks mid-count
        en = 1'b0; cd = 16'd10; bdiv = 8'd4;
        @(negedge clk); en = 1'b1;
        measure(5, s1, s2, b1, orph);
        cd = 16'd3;
        #1;
        chk("R7 quiet in change cycle", int'(sample_tick), 0);
        measure(10, s1, s2, b1, orph);
        chk("R7 first sample after cd change", s1, 2);
        // R7: bdiv change restarts bit count
        bdiv = 8'd6;
        measure(30, s1, s2, b1, orph);
        chk("R7 first bit after bdiv change", b1, 20);

        // R1: divisor at its top value
        en = 1'b0; cd = 16'hFFFF; bdiv = 8'd4;
        @(negedge clk); en = 1'b1;
        measure(65536, s1, s2, b1, orph);
        chk("R1 first sample cd=65535", s1, 65534);
        chk("R5 no bit before fifth sample", b1, -1);

        finish_run();
    end
endmodule